// File: doc/BRIEF.md
# SDRAM DQM Byte-Mask Pipeline

This block produces the per-lane DQM pins of an SDRAM data bus. It merges two control streams that reach the pins with different timing. Write masks act with zero delay: a lane's DQM bit must sit in the same cycle as the write data on the bus. Read output control acts two clocks late: a DQM bit forces the device's output for that lane to high impedance two cycles after it is sampled. The block passes write masks straight to the pins. It delays read enables so that each one lands in its DQM slot, which is `READ_ADVANCE - 2` cycles after the host presents it.

Both inputs are valid-qualified streams with no ready signal, so the block never applies back-pressure. Each cycle the block takes at most one write beat and one read beat, and it accepts every beat it is given. The host must present a read beat `READ_ADVANCE` cycles before the read data for that beat appears on the bus. When no transfer owns the DQM slot, every lane is driven high (masked). When a write beat and a delayed read beat claim the same slot, the block masks every lane rather than guess which transfer should win.

Top module: `sdram_dqm_pipe`

## Requirements
- R1: After reset with both strobes low, every lane of `dqm` is 1. Read beats offered while `rst_n` is low are dropped, so their slot shows all lanes at 1.
- R2: In a cycle with `wr_valid` low and no delayed read beat due, every lane of `dqm` is 1.
- R3: In a cycle with `wr_valid` high and no read beat due, `dqm[i]` equals `wr_mask[i]` in that same cycle. A mask bit of 1 suppresses the write to lane i and a bit of 0 lets it through.
- R4: A read beat taken in cycle t (`rd_valid` high) sets `dqm[i] = ~rd_en[i]` in cycle t + `READ_ADVANCE` - 2, provided no write beat is present in that cycle. An `rd_en` bit of 1 lets lane i drive its data and a bit of 0 forces it to high impedance.
- R5: When a write beat and a due read beat fall in the same cycle, every lane of `dqm` is 1.
- R6: Read beats in consecutive cycles keep their order and their separate lane enables. There is no ready signal and no beat is ever stalled.
- R7: When `rd_valid` is low, `rd_en` has no effect: the slot that beat would have owned shows the R2 or R3 value.
- R8: When `wr_valid` is low, `wr_mask` has no effect on `dqm`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | A write beat is on the bus in this cycle |
| wr_mask | input | LANES | Per-lane write suppress, 1 = lane not written |
| rd_valid | input | 1 | A read beat is offered, with its data due READ_ADVANCE cycles later |
| rd_en | input | LANES | Per-lane read output enable, 1 = lane drives |
| dqm | output | LANES | DQM pins, one per byte lane |

## Verification
The bench builds the block with four lanes and `READ_ADVANCE` = 4, which gives a two-stage read delay line. It walks every combination of write strobe, write mask, read strobe and read enable, 1024 beats in all. Because the read beat issued two cycles earlier is unrelated to the current write, every lane pattern reaches every outcome: idle, write only, read only and collision. A further pseudo-random stretch covers back-to-back reads, and read beats offered during reset confirm that they are dropped.

// File: rtl/sdram_dqm_pkg.sv
package sdram_dqm_pkg;
  // Clocks between a DQM sample and its effect on read output drivers.
  localparam int unsigned RD_DQM_LATENCY = 2;

  typedef enum logic [1:0] {
    SRC_IDLE  = 2'd0,
    SRC_WRITE = 2'd1,
    SRC_READ  = 2'd2,
    SRC_CLASH = 2'd3
  } dqm_src_e;

  function automatic dqm_src_e pick_src(input logic wr_v, input logic rd_v);
    dqm_src_e s;
    case ({wr_v, rd_v})
      2'b10:   s = SRC_WRITE;
      2'b01:   s = SRC_READ;
      2'b11:   s = SRC_CLASH;
      default: s = SRC_IDLE;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/dqm_rd_delay.sv
module dqm_rd_delay #(
  parameter int unsigned LANES  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_v,
  input  logic [LANES-1:0] in_en,
  output logic             out_v,
  output logic [LANES-1:0] out_en
);
  generate
    if (STAGES == 0) begin : g_direct
      assign out_v  = in_v & rst_n;
      assign out_en = in_en;
    end else begin : g_line
      logic             stage_v  [STAGES];
      logic [LANES-1:0] stage_en [STAGES];

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int s = 0; s < int'(STAGES); s++) begin
            stage_v[s]  <= 1'b0;
            stage_en[s] <= '0;
          end
        end else begin
          stage_v[0]  <= in_v;
          stage_en[0] <= in_v ? in_en : '0;
          for (int s = 1; s < int'(STAGES); s++) begin
            stage_v[s]  <= stage_v[s-1];
            stage_en[s] <= stage_en[s-1];
          end
        end
      end

      assign out_v  = stage_v[STAGES-1];
      assign out_en = stage_en[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/dqm_lane_shape.sv
module dqm_lane_shape #(
  parameter int unsigned LANES = 8
) (
  input  logic [LANES-1:0] wr_mask,
  input  logic [LANES-1:0] rd_en,
  output logic [LANES-1:0] wr_dqm,
  output logic [LANES-1:0] rd_dqm
);
  // Write mask bits are already in pin polarity; read enables are inverted.
  generate
    for (genvar i = 0; i < int'(LANES); i++) begin : g_lane
      assign wr_dqm[i] = wr_mask[i];
      assign rd_dqm[i] = ~rd_en[i];
    end
  endgenerate
endmodule

// File: rtl/dqm_merge.sv
module dqm_merge
  import sdram_dqm_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input  logic             wr_v,
  input  logic [LANES-1:0] wr_dqm,
  input  logic             rd_v,
  input  logic [LANES-1:0] rd_dqm,
  output logic [LANES-1:0] dqm
);
  dqm_src_e src;

  always_comb begin
    src = pick_src(wr_v, rd_v);
    case (src)
      SRC_WRITE: dqm = wr_dqm;
      SRC_READ:  dqm = rd_dqm;
      default:   dqm = '1;
    endcase
  end
endmodule

// File: rtl/sdram_dqm_pipe.sv
module sdram_dqm_pipe
  import sdram_dqm_pkg::*;
#(
  parameter int unsigned LANES        = 8,
  parameter int unsigned READ_ADVANCE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [LANES-1:0] wr_mask,
  input  logic             rd_valid,
  input  logic [LANES-1:0] rd_en,
  output logic [LANES-1:0] dqm
);
  localparam int unsigned RD_STAGES = READ_ADVANCE - RD_DQM_LATENCY;

  initial begin
    if (READ_ADVANCE < RD_DQM_LATENCY)
      $error("READ_ADVANCE must be at least the read DQM latency");
  end

  logic             slot_v;
  logic [LANES-1:0] slot_en;
  logic [LANES-1:0] wr_dqm;
  logic [LANES-1:0] rd_dqm;

  dqm_rd_delay #(.LANES(LANES), .STAGES(RD_STAGES)) u_delay (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_v   (rd_valid),
    .in_en  (rd_en),
    .out_v  (slot_v),
    .out_en (slot_en)
  );

  dqm_lane_shape #(.LANES(LANES)) u_shape (
    .wr_mask (wr_mask),
    .rd_en   (slot_en),
    .wr_dqm  (wr_dqm),
    .rd_dqm  (rd_dqm)
  );

  dqm_merge #(.LANES(LANES)) u_merge (
    .wr_v   (wr_valid),
    .wr_dqm (wr_dqm),
    .rd_v   (slot_v),
    .rd_dqm (rd_dqm),
    .dqm    (dqm)
  );
endmodule

// File: rtl/sdram_dqm_pipe_chk.sv
module sdram_dqm_pipe_chk #(
  parameter int unsigned LANES        = 8,
  parameter int unsigned READ_ADVANCE = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic [LANES-1:0] wr_mask,
  input logic             rd_valid,
  input logic [LANES-1:0] rd_en,
  input logic [LANES-1:0] dqm
);
  localparam int unsigned HIST = READ_ADVANCE - 2;

  logic             due_v;
  logic [LANES-1:0] due_en;

  generate
    if (HIST == 0) begin : g_now
      assign due_v  = rd_valid;
      assign due_en = rd_en;
    end else begin : g_hist
      logic             hv [HIST];
      logic [LANES-1:0] he [HIST];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int k = 0; k < int'(HIST); k++) begin
            hv[k] <= 1'b0;
            he[k] <= '0;
          end
        end else begin
          hv[0] <= rd_valid;
          he[0] <= rd_en;
          for (int k = 1; k < int'(HIST); k++) begin
            hv[k] <= hv[k-1];
            he[k] <= he[k-1];
          end
        end
      end
      assign due_v  = hv[HIST-1];
      assign due_en = he[HIST-1];
    end
  endgenerate

  // R2
  idle_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid && !due_v) |-> (dqm == {LANES{1'b1}}));

  // R3
  write_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !due_v) |-> (dqm == wr_mask));

  // R4
  read_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid && due_v) |-> (dqm == ~due_en));

  // R5
  clash_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && due_v) |-> (&dqm));
endmodule

bind sdram_dqm_pipe sdram_dqm_pipe_chk #(.LANES(LANES), .READ_ADVANCE(READ_ADVANCE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .wr_mask  (wr_mask),
  .rd_valid (rd_valid),
  .rd_en    (rd_en),
  .dqm      (dqm)
);

// File: tb/sdram_dqm_pipe_test.sv
module sdram_dqm_pipe_test;
  localparam int CLK_PERIOD = 10;
  localparam int L  = 4;
  localparam int RA = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_valid = 1'b0;
  logic [L-1:0] wr_mask = '0;
  logic         rd_valid = 1'b0;
  logic [L-1:0] rd_en = '0;
  logic [L-1:0] dqm;

  int errors = 0;
  int checks = 0;

  // Bench-side record of read beats: index 0 = previous cycle, 1 = two back.
  logic         hv [2];
  logic [L-1:0] he [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_dqm_pipe #(.LANES(L), .READ_ADVANCE(RA)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_mask(wr_mask),
    .rd_valid(rd_valid), .rd_en(rd_en), .dqm(dqm)
  );

  task automatic check(input string req, input logic [L-1:0] exp);
    checks++;
    if (dqm !== exp) begin
      errors++;
      $display("FAIL %s: dqm=%b expected=%b", req, dqm, exp);
    end
  endtask

  // Drive one beat after the falling edge, check the slot, then advance the record.
  task automatic beat(input logic wv, input logic [L-1:0] wm,
                      input logic rv, input logic [L-1:0] re);
    logic [L-1:0] exp;
    string req;
    @(negedge clk);
    wr_valid = wv; wr_mask = wm; rd_valid = rv; rd_en = re;
    #1;
    if (wv && hv[1])      begin exp = '1;      req = "R5"; end
    else if (wv)          begin exp = wm;      req = hv[1] ? "R3" : "R3/R7"; end
    else if (hv[1])       begin exp = ~he[1];  req = "R4/R6/R8"; end
    else                  begin exp = '1;      req = "R2/R7/R8"; end
    check(req, exp);
    hv[1] = hv[0]; he[1] = he[0];
    hv[0] = rst_n & rv; he[0] = re;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    hv[0] = 1'b0; hv[1] = 1'b0; he[0] = '0; he[1] = '0;
    // R1: reset state, with a read beat offered during reset that must be dropped
    repeat (2) @(negedge clk);
    rd_valid = 1'b1; rd_en = '1;
    @(negedge clk);
    #1;
    check("R1", '1);
    @(negedge clk);
    rd_valid = 1'b0; rd_en = '0;
    rst_n = 1'b1;
    #1;
    check("R1", '1);
    beat(1'b0, '0, 1'b0, '0);
    check("R1", '1);
    beat(1'b0, '0, 1'b0, '0);
    check("R1", '1);

    // R2..R8: full sweep of strobes and lane patterns
    for (int n = 0; n < 1024; n++) begin
      beat(n[9], n[3:0], n[8], n[7:4]);
    end

    // R6: back-to-back reads with distinct enables, then drain
    for (int n = 0; n < 16; n++) beat(1'b0, '0, 1'b1, n[3:0]);
    beat(1'b0, '0, 1'b0, '0);
    beat(1'b0, '0, 1'b0, '0);

    // Pseudo-random mix
    lfsr = 16'hACE1;
    for (int n = 0; n < 2000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      beat(lfsr[0], lfsr[4:1], lfsr[5] | lfsr[6], lfsr[10:7]);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule